// File: doc/BRIEF.md
# Code-Density Linearity Analyzer

The block collects output codes from an N-bit converter under test while a slow, repeated linear ramp sweeps its input. For each possible code it keeps a hit counter. After many ramp periods, typically around one to a few hundred, every code has collected enough hits for a fine measurement. When accumulation ends, a sequential pass computes three results:

- the mean hit count over the interior codes;
- each interior code's differential linearity error (DLE), normalised to that mean;
- the integral linearity error (ILE), formed by trapezoidal integration of adjacent DLE values.

It also computes root-mean-square summaries of both error curves. All results are signed fixed point with 8 fractional bits, so 256 equals one LSB.

Software or a test sequencer drives the controls in this order: clear, start, stream samples, finish, then wait for the done flag. Once done is set, per-code results are read through an address-indexed readout port. The two end codes absorb out-of-range input, so they are counted but left out of the analysis.

Top module: `cdl_analyzer`

## Requirements
- R1: After reset, every bin count, DLE, ILE and RMS output reads zero, and busy_o, done_o and ovf_o are low.
- R2: A sample is counted only while accumulating, which is the period after start_i and up to and including the cycle that finish_i is sampled. In idle, compute and done states, samples leave every count unchanged.
- R3: Each bin counter stops at 2^CNT_W-1 instead of wrapping. A hit on a full bin sets ovf_o, which stays set until clear_i.
- R4: The mean is A = floor(256*S/(2^CODE_W-2)), where S is the sum of the interior counts. For count c, DLE = sign(256c-A) * floor(256*|256c-A| / A), limited to the signed FX_W range. A missing code gives -256, and A = 0 gives a DLE of 0 for every code.
- R5: ILE for interior code i is ILE[i-1] + floor((DLE[i]+DLE[i-1])/2), limited to the signed FX_W range. Both ILE and DLE are taken as 0 at code 0.
- R6: Codes 0 and 2^CODE_W-1 are left out of the mean and report DLE = ILE = 0, while their counts are still reported.
- R7: dnl_rms_o = floor(sqrt(floor(sum of DLE^2 / (2^CODE_W-2)))), summed over the interior codes. inl_rms_o is formed the same way from ILE.
- R8: busy_o is high from the cycle after finish_i until the results are complete. done_o then stays high until start_i or clear_i. A start_i issued from done resumes accumulating on top of the existing counts.
- R9: clear_i zeroes every count, result and flag, and returns the block to idle by the next cycle.
- R10: rd_count_o, rd_dle_o and rd_ile_o show the entry selected by rd_addr_i in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin or resume accumulation |
| clear_i | input | 1 | Zero all counts, results and flags |
| finish_i | input | 1 | End accumulation and start analysis |
| sample_valid_i | input | 1 | Sample strobe |
| sample_code_i | input | CODE_W | Converter output code |
| rd_addr_i | input | CODE_W | Readout code index |
| rd_count_o | output | CNT_W | Hit count of the addressed code |
| rd_dle_o | output | FX_W | DLE of the addressed code, signed Q8 |
| rd_ile_o | output | FX_W | ILE of the addressed code, signed Q8 |
| dnl_rms_o | output | FX_W | RMS of DLE, unsigned Q8 |
| inl_rms_o | output | FX_W | RMS of ILE, unsigned Q8 |
| busy_o | output | 1 | Analysis in progress |
| done_o | output | 1 | Results valid |
| ovf_o | output | 1 | Sticky bin saturation flag |

## Verification
A wrong bin counter shows up on rd_count_o one cycle after the faulty sample. It also spreads into every later ILE value and both RMS outputs once analysis ends. A wrong mean moves every DLE by a common factor. A fault in the integration step leaves DLE correct but corrupts ILE from the faulty code upward. A stuck sequencer shows as busy_o remaining high and done_o never rising.

// File: rtl/cdl_pkg.sv
package cdl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_CALC, ST_DONE} cdl_state_e;
  typedef enum logic [2:0] {PH_SUM, PH_AVG, PH_DLE, PH_MD, PH_SD, PH_MI, PH_SI} cdl_phase_e;
endpackage

// File: rtl/cdl_div.sv
module cdl_div #(
  parameter int W = 36
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] quo_o,
  output logic         done_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;
  logic [W:0]    trial_w;

  assign trial_w = {rem_q, quo_q[W-1]} - {1'b0, den_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q <= '0;
        quo_q <= num_i;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (!trial_w[W]) begin
          rem_q <= trial_w[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= {rem_q[W-2:0], quo_q[W-1]};
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign quo_o  = quo_q;
  assign done_o = done_q;
endmodule

// File: rtl/cdl_isqrt.sv
module cdl_isqrt #(
  parameter int W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [2*W-1:0] val_i,
  output logic [W-1:0]   root_o,
  output logic           done_o
);
  localparam int BW = $clog2(W);

  logic [2*W-1:0] val_q, csq_w;
  logic [W-1:0]   res_q, cand_w;
  logic [BW-1:0]  bit_q;
  logic           run_q, done_q;

  assign cand_w = res_q | (W'(1) << bit_q);
  assign csq_w  = {{W{1'b0}}, cand_w} * {{W{1'b0}}, cand_w};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      res_q  <= '0;
      bit_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        val_q <= val_i;
        res_q <= '0;
        bit_q <= BW'(W - 1);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (csq_w <= val_q) res_q <= cand_w;
        if (bit_q == '0) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          bit_q <= bit_q - BW'(1);
        end
      end
    end
  end

  assign root_o = res_q;
  assign done_o = done_q;
endmodule

// File: rtl/cdl_analyzer.sv
module cdl_analyzer
  import cdl_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 12,
  parameter int FRAC   = 8,
  parameter int FX_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              clear_i,
  input  logic              finish_i,
  input  logic              sample_valid_i,
  input  logic [CODE_W-1:0] sample_code_i,
  input  logic [CODE_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_count_o,
  output logic [FX_W-1:0]   rd_dle_o,
  output logic [FX_W-1:0]   rd_ile_o,
  output logic [FX_W-1:0]   dnl_rms_o,
  output logic [FX_W-1:0]   inl_rms_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              ovf_o
);
  localparam int NC     = 1 << CODE_W;
  localparam int NINT   = NC - 2;
  localparam int TOT_W  = CNT_W + CODE_W;
  localparam int AVG_W  = TOT_W + FRAC;
  localparam int SQ_W   = 2 * FX_W + CODE_W;
  localparam int NUM_W  = AVG_W + FRAC + 1;
  localparam int DIV_W  = (SQ_W > NUM_W) ? SQ_W : NUM_W;
  localparam logic [CNT_W-1:0]      CNT_MAX = '1;
  localparam logic [CODE_W-1:0]     IDX_LO  = CODE_W'(1);
  localparam logic [CODE_W-1:0]     IDX_HI  = CODE_W'(NC - 2);
  localparam logic [DIV_W-1:0]      POS_LIM = DIV_W'(2 ** (FX_W - 1) - 1);
  localparam logic signed [FX_W+1:0] ILE_HI = (FX_W + 2)'(2 ** (FX_W - 1) - 1);
  localparam logic signed [FX_W+1:0] ILE_LO = ~ILE_HI;

  cdl_state_e state_q;
  cdl_phase_e phase_q;

  logic [CNT_W-1:0]       hist_q [NC];
  logic signed [FX_W-1:0] dle_q [NC];
  logic signed [FX_W-1:0] ile_q [NC];
  logic [CODE_W-1:0]      idx_q;
  logic [TOT_W-1:0]       total_q;
  logic [AVG_W-1:0]       avg_q;
  logic [SQ_W-1:0]        sq_d_q, sq_i_q;
  logic [2*FX_W-1:0]      mean_q;
  logic signed [FX_W-1:0] prev_dle_q, prev_ile_q;
  logic [FX_W-1:0]        dnl_q, inl_q;
  logic                   issued_q, ovf_q;
  logic                   acc_w;

  assign acc_w = (state_q == ST_ACC);

  // histogram bins
  for (genvar g = 0; g < NC; g++) begin : g_bin
    logic hit_w;
    assign hit_w = acc_w && sample_valid_i && (sample_code_i == CODE_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             hist_q[g] <= '0;
      else if (clear_i)                        hist_q[g] <= '0;
      else if (hit_w && hist_q[g] != CNT_MAX)  hist_q[g] <= hist_q[g] + CNT_W'(1);
    end
  end

  // shared arithmetic units
  logic              div_start, div_done, sq_start, sq_done;
  logic [DIV_W-1:0]  div_num, div_den, div_quo;
  logic [FX_W-1:0]   sq_root;
  logic [AVG_W-1:0]  cur_w, absd_w;
  logic              neg_w, avg_zero_w, step_w;

  assign cur_w      = AVG_W'({hist_q[idx_q], {FRAC{1'b0}}});
  assign neg_w      = cur_w < avg_q;
  assign absd_w     = neg_w ? (avg_q - cur_w) : (cur_w - avg_q);
  assign avg_zero_w = (avg_q == '0);

  always_comb begin
    div_num = '0;
    div_den = DIV_W'(NINT);
    unique case (phase_q)
      PH_AVG:  div_num = DIV_W'(total_q) << FRAC;
      PH_DLE: begin
        div_num = DIV_W'(absd_w) << FRAC;
        div_den = DIV_W'(avg_q);
      end
      PH_MD:   div_num = DIV_W'(sq_d_q);
      PH_MI:   div_num = DIV_W'(sq_i_q);
      default: ;
    endcase
  end

  assign div_start = (state_q == ST_CALC) && !issued_q &&
                     ((phase_q == PH_AVG) || (phase_q == PH_MD) || (phase_q == PH_MI) ||
                      ((phase_q == PH_DLE) && !avg_zero_w));
  assign sq_start  = (state_q == ST_CALC) && !issued_q &&
                     ((phase_q == PH_SD) || (phase_q == PH_SI));
  assign step_w    = avg_zero_w || div_done;

  cdl_div #(.W(DIV_W)) u_div (
    .clk_i (clk_i), .rst_ni(rst_ni), .start_i(div_start),
    .num_i (div_num), .den_i(div_den), .quo_o(div_quo), .done_o(div_done)
  );

  cdl_isqrt #(.W(FX_W)) u_sqrt (
    .clk_i (clk_i), .rst_ni(rst_ni), .start_i(sq_start),
    .val_i (mean_q), .root_o(sq_root), .done_o(sq_done)
  );

  // per-code DLE / ILE step
  logic signed [FX_W-1:0]   dle_v, ile_v;
  logic signed [FX_W:0]     pair_w, half_w;
  logic signed [FX_W+1:0]   ile_raw;
  logic signed [2*FX_W-1:0] dsq_w, isq_w;

  always_comb begin
    if (avg_zero_w)                dle_v = '0;
    else if (!neg_w)               dle_v = (div_quo > POS_LIM) ? POS_LIM[FX_W-1:0] : div_quo[FX_W-1:0];
    else if (div_quo > POS_LIM)    dle_v = {1'b1, {(FX_W-1){1'b0}}};
    else                           dle_v = -div_quo[FX_W-1:0];
    pair_w  = {dle_v[FX_W-1], dle_v} + {prev_dle_q[FX_W-1], prev_dle_q};
    half_w  = pair_w >>> 1;
    ile_raw = {{2{prev_ile_q[FX_W-1]}}, prev_ile_q} + {half_w[FX_W], half_w};
    if (ile_raw > ILE_HI)          ile_v = ILE_HI[FX_W-1:0];
    else if (ile_raw < ILE_LO)     ile_v = ILE_LO[FX_W-1:0];
    else                           ile_v = ile_raw[FX_W-1:0];
    dsq_w = dle_v * dle_v;
    isq_w = ile_v * ile_v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || clear_i) begin
      state_q    <= ST_IDLE;
      phase_q    <= PH_SUM;
      idx_q      <= IDX_LO;
      total_q    <= '0;
      avg_q      <= '0;
      sq_d_q     <= '0;
      sq_i_q     <= '0;
      mean_q     <= '0;
      prev_dle_q <= '0;
      prev_ile_q <= '0;
      dnl_q      <= '0;
      inl_q      <= '0;
      issued_q   <= 1'b0;
      ovf_q      <= 1'b0;
      for (int k = 0; k < NC; k++) begin
        dle_q[k] <= '0;
        ile_q[k] <= '0;
      end
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: if (start_i) state_q <= ST_ACC;
        ST_ACC: begin
          if (sample_valid_i && hist_q[sample_code_i] == CNT_MAX) ovf_q <= 1'b1;
          if (finish_i) begin
            state_q    <= ST_CALC;
            phase_q    <= PH_SUM;
            idx_q      <= IDX_LO;
            total_q    <= '0;
            sq_d_q     <= '0;
            sq_i_q     <= '0;
            prev_dle_q <= '0;
            prev_ile_q <= '0;
            issued_q   <= 1'b0;
          end
        end
        ST_CALC: begin
          if (div_start || sq_start) issued_q <= 1'b1;
          unique case (phase_q)
            PH_SUM: begin
              total_q <= total_q + TOT_W'(hist_q[idx_q]);
              if (idx_q == IDX_HI) begin
                idx_q   <= IDX_LO;
                phase_q <= PH_AVG;
              end else idx_q <= idx_q + CODE_W'(1);
            end
            PH_AVG: if (div_done) begin
              avg_q    <= div_quo[AVG_W-1:0];
              issued_q <= 1'b0;
              phase_q  <= PH_DLE;
            end
            PH_DLE: if (step_w) begin
              dle_q[idx_q] <= dle_v;
              ile_q[idx_q] <= ile_v;
              prev_dle_q   <= dle_v;
              prev_ile_q   <= ile_v;
              sq_d_q       <= sq_d_q + SQ_W'($unsigned(dsq_w));
              sq_i_q       <= sq_i_q + SQ_W'($unsigned(isq_w));
              issued_q     <= 1'b0;
              if (idx_q == IDX_HI) phase_q <= PH_MD;
              else idx_q <= idx_q + CODE_W'(1);
            end
            PH_MD, PH_MI: if (div_done) begin
              mean_q   <= div_quo[2*FX_W-1:0];
              issued_q <= 1'b0;
              phase_q  <= (phase_q == PH_MD) ? PH_SD : PH_SI;
            end
            PH_SD: if (sq_done) begin
              dnl_q    <= sq_root;
              issued_q <= 1'b0;
              phase_q  <= PH_MI;
            end
            PH_SI: if (sq_done) begin
              inl_q    <= sq_root;
              issued_q <= 1'b0;
              state_q  <= ST_DONE;
            end
            default: phase_q <= PH_SUM;
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_count_o = hist_q[rd_addr_i];
  assign rd_dle_o   = dle_q[rd_addr_i];
  assign rd_ile_o   = ile_q[rd_addr_i];
  assign dnl_rms_o  = dnl_q;
  assign inl_rms_o  = inl_q;
  assign busy_o     = (state_q == ST_CALC);
  assign done_o     = (state_q == ST_DONE);
  assign ovf_o      = ovf_q;
endmodule

// File: rtl/cdl_analyzer_chk.sv
module cdl_analyzer_chk #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 12,
  parameter int FX_W   = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              acc_i,
  input logic [CODE_W-1:0] rd_addr_i,
  input logic [CNT_W-1:0]  rd_count_o,
  input logic [FX_W-1:0]   rd_dle_o,
  input logic [FX_W-1:0]   rd_ile_o,
  input logic [FX_W-1:0]   dnl_rms_o,
  input logic [FX_W-1:0]   inl_rms_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              ovf_o
);
  a_r2_no_count_outside_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_i && !clear_i) |=> (rd_addr_i != $past(rd_addr_i)) || (rd_count_o == $past(rd_count_o)));

  a_r3_step_of_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (rd_addr_i != $past(rd_addr_i)) || (rd_count_o == $past(rd_count_o)) ||
                 ({1'b0, rd_count_o} == {1'b0, $past(rd_count_o)} + 1'b1));

  a_r3_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clear_i) |=> ovf_o);

  a_r6_end_codes_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (rd_addr_i == '0 || rd_addr_i == '1)) |-> (rd_dle_o == '0 && rd_ile_o == '0));

  a_r8_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));

  a_r9_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (rd_count_o == '0 && !done_o && !busy_o && !ovf_o &&
                 dnl_rms_o == '0 && inl_rms_o == '0));
endmodule

bind cdl_analyzer cdl_analyzer_chk #(.CODE_W(CODE_W), .CNT_W(CNT_W), .FX_W(FX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clear_i   (clear_i),
  .acc_i     (acc_w),
  .rd_addr_i (rd_addr_i),
  .rd_count_o(rd_count_o),
  .rd_dle_o  (rd_dle_o),
  .rd_ile_o  (rd_ile_o),
  .dnl_rms_o (dnl_rms_o),
  .inl_rms_o (inl_rms_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .ovf_o     (ovf_o)
);

// File: tb/sim_cdl_analyzer.sv
module sim_cdl_analyzer;
  localparam int CODE_W = 4;
  localparam int CNT_W  = 12;
  localparam int FX_W   = 16;
  localparam int NC     = 16;
  localparam int NINT   = 14;
  localparam longint CMAX = 4095;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, clear = 1'b0, finish = 1'b0, valid = 1'b0;
  logic [CODE_W-1:0] code = '0, addr = '0;
  logic [CNT_W-1:0]  cnt_o;
  logic [FX_W-1:0]   dle_o, ile_o, dnl_o, inl_o;
  logic              busy, done, ovf;

  always #4 clk = ~clk;

  cdl_analyzer u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .clear_i(clear), .finish_i(finish),
    .sample_valid_i(valid), .sample_code_i(code), .rd_addr_i(addr),
    .rd_count_o(cnt_o), .rd_dle_o(dle_o), .rd_ile_o(ile_o),
    .dnl_rms_o(dnl_o), .inl_rms_o(inl_o), .busy_o(busy), .done_o(done), .ovf_o(ovf)
  );

  int nchk = 0, nerr = 0;
  longint exp_cnt [NC];
  longint exp_dle [NC];
  longint exp_ile [NC];
  longint exp_dnl, exp_inl;

  task automatic chk(string tag, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint isqrt(longint x);
    longint r = 0;
    while ((r + 1) * (r + 1) <= x) r++;
    return r;
  endfunction

  function automatic longint clamp16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic model();
    longint tot = 0, avg, pd = 0, pi = 0, sd = 0, si = 0;
    for (int i = 1; i <= NINT; i++) tot += exp_cnt[i];
    avg = (tot * 256) / NINT;
    exp_dle[0] = 0; exp_ile[0] = 0; exp_dle[NC-1] = 0; exp_ile[NC-1] = 0;
    for (int i = 1; i <= NINT; i++) begin
      longint cur = exp_cnt[i] * 256;
      longint d, il;
      if (avg == 0) d = 0;
      else if (cur < avg) d = clamp16(-(((avg - cur) * 256) / avg));
      else d = clamp16(((cur - avg) * 256) / avg);
      il = clamp16(pi + ((d + pd) >>> 1));
      exp_dle[i] = d; exp_ile[i] = il;
      sd += d * d; si += il * il;
      pd = d; pi = il;
    end
    exp_dnl = isqrt(sd / NINT);
    exp_inl = isqrt(si / NINT);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic feed(int c, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      valid = 1'b1;
      code  = CODE_W'(c);
    end
    @(negedge clk) valid = 1'b0;
  endtask

  task automatic feed_model(int c, int n);
    feed(c, n);
    exp_cnt[c] = (exp_cnt[c] + n > CMAX) ? CMAX : exp_cnt[c] + n;
  endtask

  task automatic run_calc();
    int t = 0;
    @(negedge clk) finish = 1'b1;
    @(negedge clk) finish = 1'b0;
    chk("R8 busy after finish", busy, 1);
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk("R8 done reached", done, 1);
    chk("R8 busy low at done", busy, 0);
  endtask

  task automatic cmp_all(string tag);
    model();
    for (int a = 0; a < NC; a++) begin
      @(negedge clk) addr = CODE_W'(a);
      #1;
      chk({tag, " R10 count"}, cnt_o, exp_cnt[a]);
      if (a == 0 || a == NC - 1) begin
        chk({tag, " R6 end dle"}, $signed(dle_o), 0);
        chk({tag, " R6 end ile"}, $signed(ile_o), 0);
      end else begin
        chk({tag, " R4 dle"}, $signed(dle_o), exp_dle[a]);
        chk({tag, " R5 ile"}, $signed(ile_o), exp_ile[a]);
      end
    end
    chk({tag, " R7 dnl rms"}, dnl_o, exp_dnl);
    chk({tag, " R7 inl rms"}, inl_o, exp_inl);
  endtask

  task automatic do_clear();
    @(negedge clk) clear = 1'b1;
    @(negedge clk) clear = 1'b0;
    for (int i = 0; i < NC; i++) exp_cnt[i] = 0;
  endtask

  task automatic t_reset();
    chk("R1 done", done, 0);
    chk("R1 busy", busy, 0);
    chk("R1 ovf", ovf, 0);
    chk("R1 dnl", dnl_o, 0);
    chk("R1 inl", inl_o, 0);
    for (int a = 0; a < NC; a++) begin
      @(negedge clk) addr = CODE_W'(a);
      #1 chk("R1 count", cnt_o, 0);
    end
  endtask

  task automatic t_ignore_idle();
    feed(3, 5);
    feed(9, 5);
    @(negedge clk) addr = 4'd3;
    #1 chk("R2 idle sample ignored", cnt_o, 0);
    addr = 4'd9;
    #1 chk("R2 idle sample ignored", cnt_o, 0);
  endtask

  task automatic t_uniform();
    pulse_start();
    for (int r = 0; r < 10; r++)
      for (int c = 0; c < NC; c++) feed_model(c, 1);
    run_calc();
    cmp_all("uniform");
  endtask

  task automatic t_pattern();
    do_clear();
    pulse_start();
    for (int c = 0; c < NC; c++) begin
      int n = (c == 0 || c == NC - 1) ? 50 : (c == 6 ? 0 : 20 + (c * 7) % 11);
      if (n > 0) feed_model(c, n);
    end
    run_calc();
    cmp_all("pattern");
    @(negedge clk) addr = 4'd6;
    #1 chk("R4 missing code dle", $signed(dle_o), -256);
    feed(3, 4);
    @(negedge clk) addr = 4'd3;
    #1 chk("R2 done sample ignored", cnt_o, exp_cnt[3]);
    chk("R8 done held", done, 1);
  endtask

  task automatic t_resume();
    pulse_start();
    chk("R8 done drops on start", done, 0);
    for (int c = 2; c < 10; c++) feed_model(c, 5);
    run_calc();
    cmp_all("resume");
  endtask

  task automatic t_clear();
    do_clear();
    chk("R9 done cleared", done, 0);
    chk("R9 dnl cleared", dnl_o, 0);
    chk("R9 inl cleared", inl_o, 0);
    @(negedge clk) addr = 4'd8;
    #1 chk("R9 count cleared", cnt_o, 0);
    chk("R9 dle cleared", $signed(dle_o), 0);
  endtask

  task automatic t_zero_avg();
    pulse_start();
    feed_model(0, 30);
    feed_model(NC - 1, 30);
    run_calc();
    cmp_all("zero_avg");
  endtask

  task automatic t_saturate();
    do_clear();
    pulse_start();
    feed_model(5, 4100);
    feed_model(6, 1);
    feed_model(7, 3);
    chk("R3 ovf set", ovf, 1);
    run_calc();
    cmp_all("saturate");
    @(negedge clk) addr = 4'd5;
    #1 chk("R3 saturated count", cnt_o, CMAX);
    chk("R3 ovf held", ovf, 1);
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < NC; i++) exp_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ignore_idle();
    t_uniform();
    t_pattern();
    t_resume();
    t_clear();
    t_zero_avg();
    t_saturate();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule